// File: doc/BRIEF.md
# Dual Blink Counter PWM Generator

This block drives a bank of GPIO output lines and can replace the static value of any line with a blink (PWM) waveform. Two counter sets, A and B, run all the time. Each set produces a waveform that stays high for a programmed number of clock cycles and then low for another programmed number. The period is the sum of the two counts.

Each line has three register bits: a static output bit, a direction bit and a blink enable bit. A fourth bit, in the set-select register, picks counter A or counter B for the line. All lines that use the same set blink in phase.

Software programs the durations and the per-line registers through a write-only, word-addressed register bus. A new duration does not cut the phase that is running. It takes effect at the next phase boundary of its counter.

Top module: `blink_pwm_gen`

## Requirements
- R1: After a synchronous active-low reset, the following values hold:
    - the static output, set-select and blink enable registers are all 0;
    - the direction register is all ones, so every line is an input;
    - all four duration registers hold 1;
    - both counters are at the start of their high phase;
    - `line_out` and `line_oe` are 0.
- R2: `line_oe[i]` is the inverse of direction bit i. A line whose blink is not active drives its static output bit on `line_out[i]`. When blink enable is cleared, the line returns to its static bit.
- R3: A counter's waveform is high for exactly `on` clock cycles and then low for exactly `off` clock cycles. This repeats without a gap.
- R4: A duration value of 0 means 2^CNT_W cycles (2^32 with the default width).
- R5: Set-select bit i picks the waveform for line i: 0 picks set A and 1 picks set B.
- R6: The waveform reaches `line_out[i]` only when blink enable bit i is 1 and direction bit i is 0 (output). On an input line (direction 1) with blink enabled, `line_out[i]` keeps the static bit.
- R7: A duration write does not change the phase in progress. The counter loads the new value when its next phase of that kind begins.
- R8: Both counters run whether or not any line uses them. Lines that select the same set show the same value in every cycle.
- R9: The register word addresses are listed below. A write to any other word index changes nothing.

  | Word index | Byte offset | Register |
  |---|---|---|
  | 0 | 0x00 | set A on-duration |
  | 1 | 0x04 | set A off-duration |
  | 2 | 0x08 | set B on-duration |
  | 3 | 0x0C | set B off-duration |
  | 8 | 0x20 | set-select |
  | 9 | 0x24 | static output |
  | 10 | 0x28 | direction |
  | 11 | 0x2C | blink enable |

  Line registers take `wr_data[NUM_LINES-1:0]` and duration registers take `wr_data[CNT_W-1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all durations count its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Word index of the register written |
| wr_data | input | DATA_W | Write data |
| line_out | output | NUM_LINES | Per-line output value |
| line_oe | output | NUM_LINES | Per-line output enable (1 = line is an output) |

## Verification
The bench measures whole high and low runs on the lines themselves. An off-by-one in the terminal count shows up as runs one cycle too long or too short. A zero duration that is taken literally gives a one-cycle or stuck phase instead of a 2^CNT_W-cycle phase.

One duration is rewritten in the middle of a high phase. A design that reloads at once would cut that phase short instead of finishing it at the old length.

Further checks cover the following mistakes:
- a blink that leaks onto an input line;
- inverted set selection, which puts the wrong period on a line;
- counters that restart per line, which breaks phase alignment between lines on one set;
- decode aliasing, where a write to an unused word index changes state.

// File: rtl/blink_pwm_pkg.sv
// Package: shared constants and types for the dual blink counter generator.
// Assumes a word-addressed bus; the indexes below are byte offsets divided by 4.
package blink_pwm_pkg;

    // Number of counter sets (A and B); the set-select register is one bit per line
    localparam int NUM_SETS = 2;

    // Word indexes of the register map
    localparam int IDX_ON_A  = 0;
    localparam int IDX_OFF_A = 1;
    localparam int IDX_ON_B  = 2;
    localparam int IDX_OFF_B = 3;
    localparam int IDX_SEL   = 8;
    localparam int IDX_OUT   = 9;
    localparam int IDX_DIR   = 10;
    localparam int IDX_EN    = 11;

    // Phase of a blink counter
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } blink_phase_e;

endpackage

// File: rtl/blink_regs.sv
// Module: blink_regs
// Write-only register file for the generator. It holds four duration registers
// (on/off per counter set) and four per-line registers: set-select, static
// output, direction and blink enable.
// Assumes at most one write per cycle and a word index on wr_addr.
// Unmapped indexes are ignored.
module blink_regs
    import blink_pwm_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int CNT_W     = 32,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [DATA_W-1:0]                  wr_data,
    output logic [NUM_SETS-1:0][CNT_W-1:0]     dur_on,
    output logic [NUM_SETS-1:0][CNT_W-1:0]     dur_off,
    output logic [NUM_LINES-1:0]               sel_q,
    output logic [NUM_LINES-1:0]               out_q,
    output logic [NUM_LINES-1:0]               dir_q,
    output logic [NUM_LINES-1:0]               en_q
);

    localparam logic [CNT_W-1:0]     DUR_RESET = CNT_W'(1);
    localparam logic [NUM_LINES-1:0] ALL_ONES  = '1;

    // Per-register write strobes decoded from the word index
    logic hit_sel, hit_out, hit_dir, hit_en;

    // Decode the line register strobes
    always_comb begin
        hit_sel = wr_en && (wr_addr == ADDR_W'(IDX_SEL));
        hit_out = wr_en && (wr_addr == ADDR_W'(IDX_OUT));
        hit_dir = wr_en && (wr_addr == ADDR_W'(IDX_DIR));
        hit_en  = wr_en && (wr_addr == ADDR_W'(IDX_EN));
    end

    // One on/off duration pair per counter set
    for (genvar s = 0; s < NUM_SETS; s++) begin : g_dur
        localparam int ON_IDX  = (s == 0) ? IDX_ON_A  : IDX_ON_B;
        localparam int OFF_IDX = (s == 0) ? IDX_OFF_A : IDX_OFF_B;

        logic hit_on, hit_off;

        // Decode the duration strobes of this set
        always_comb begin
            hit_on  = wr_en && (wr_addr == ADDR_W'(ON_IDX));
            hit_off = wr_en && (wr_addr == ADDR_W'(OFF_IDX));
        end

        // Hold the on/off durations of this set
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dur_on[s]  <= DUR_RESET;
                dur_off[s] <= DUR_RESET;
            end else begin
                if (hit_on)  dur_on[s]  <= wr_data[CNT_W-1:0];
                if (hit_off) dur_off[s] <= wr_data[CNT_W-1:0];
            end
        end

        assert_dur_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_addr == ADDR_W'(ON_IDX) || wr_addr == ADDR_W'(OFF_IDX)))
            |=> ($stable(dur_on[s]) && $stable(dur_off[s])));
    end

    // Hold the per-line registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            out_q <= '0;
            dir_q <= ALL_ONES;
            en_q  <= '0;
        end else begin
            if (hit_sel) sel_q <= wr_data[NUM_LINES-1:0];
            if (hit_out) out_q <= wr_data[NUM_LINES-1:0];
            if (hit_dir) dir_q <= wr_data[NUM_LINES-1:0];
            if (hit_en)  en_q  <= wr_data[NUM_LINES-1:0];
        end
    end

    assert_line_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(sel_q) && $stable(out_q) && $stable(dir_q) && $stable(en_q)));

endmodule

// File: rtl/blink_counter.sv
// Module: blink_counter
// Free-running on/off phase counter for one set. The waveform is high for
// on_len cycles and then low for off_len cycles.
// Assumes the length registers may change at any time. The length of a phase
// is captured when that phase begins, and a value of 0 counts 2^CNT_W cycles.
module blink_counter
    import blink_pwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] on_len,
    input  logic [CNT_W-1:0] off_len,
    output logic             wave
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    blink_phase_e     phase;
    logic [CNT_W-1:0] cnt;       // cycles already spent in the current phase
    logic [CNT_W-1:0] cur_len;   // length captured for the current phase
    logic [CNT_W-1:0] last_idx;  // index of the final cycle of the phase
    logic             term;

    // Final cycle index; a length of 0 wraps to all ones, i.e. 2^CNT_W cycles
    always_comb begin
        last_idx = cur_len - ONE;
        term     = (cnt == last_idx);
    end

    // Advance the phase counter and capture the next phase length at each boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_HIGH;
            cnt     <= '0;
            cur_len <= ONE;
        end else if (term) begin
            cnt <= '0;
            if (phase == PH_HIGH) begin
                phase   <= PH_LOW;
                cur_len <= off_len;
            end else begin
                phase   <= PH_HIGH;
                cur_len <= on_len;
            end
        end else begin
            cnt <= cnt + ONE;
        end
    end

    // Drive the waveform from the phase
    always_comb wave = (phase == PH_HIGH);

    assert_cnt_bound_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last_idx);

    assert_len_midphase_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != last_idx) |=> ($stable(cur_len) && $stable(phase)));

    assert_phase_start_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        (phase != $past(phase)) |-> (cnt == '0));

    assert_zero_len_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        (cur_len == '0 && cnt == ONE) |=> (phase == $past(phase)));

endmodule

// File: rtl/blink_line_mux.sv
// Module: blink_line_mux
// Per-line output selection. Each line picks the waveform of its selected set.
// The waveform is used only when the line is an output with blink enabled;
// otherwise the line drives its static output bit.
// Assumes exactly two sets, so the set select is one bit per line.
module blink_line_mux
    import blink_pwm_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic [NUM_SETS-1:0]  wave,
    input  logic [NUM_LINES-1:0] sel_q,
    input  logic [NUM_LINES-1:0] out_q,
    input  logic [NUM_LINES-1:0] dir_q,
    input  logic [NUM_LINES-1:0] en_q,
    output logic [NUM_LINES-1:0] line_out,
    output logic [NUM_LINES-1:0] line_oe
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic picked;
        logic blink_on;

        // Choose the set waveform and decide whether blink overrides the static bit
        always_comb begin
            picked      = sel_q[i] ? wave[1] : wave[0];
            blink_on    = en_q[i] && !dir_q[i];
            line_out[i] = blink_on ? picked : out_q[i];
            line_oe[i]  = !dir_q[i];
        end
    end

endmodule

// File: rtl/blink_pwm_gen.sv
// Module: blink_pwm_gen (top)
// Dual blink counter PWM generator for a bank of GPIO lines. It joins the
// register file, two free-running counter sets and the per-line output mux.
// Assumes a single clock domain and a synchronous active-low reset.
module blink_pwm_gen
    import blink_pwm_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int CNT_W     = 32,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [NUM_LINES-1:0] line_out,
    output logic [NUM_LINES-1:0] line_oe
);

    logic [NUM_SETS-1:0][CNT_W-1:0] dur_on;
    logic [NUM_SETS-1:0][CNT_W-1:0] dur_off;
    logic [NUM_LINES-1:0]           sel_q, out_q, dir_q, en_q;
    logic [NUM_SETS-1:0]            wave;

    blink_regs #(
        .NUM_LINES (NUM_LINES),
        .CNT_W     (CNT_W),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .dur_on  (dur_on),
        .dur_off (dur_off),
        .sel_q   (sel_q),
        .out_q   (out_q),
        .dir_q   (dir_q),
        .en_q    (en_q)
    );

    // One free-running counter per set
    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        blink_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .on_len  (dur_on[s]),
            .off_len (dur_off[s]),
            .wave    (wave[s])
        );
    end

    blink_line_mux #(
        .NUM_LINES (NUM_LINES)
    ) u_mux (
        .wave     (wave),
        .sel_q    (sel_q),
        .out_q    (out_q),
        .dir_q    (dir_q),
        .en_q     (en_q),
        .line_out (line_out),
        .line_oe  (line_oe)
    );

    assert_input_static_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (line_out & ~line_oe) == (out_q & ~line_oe));

    assert_idle_static_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> (line_out == out_q));

    assert_same_set_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        ((en_q[0] && !dir_q[0] && en_q[1] && !dir_q[1] && (sel_q[0] == sel_q[1])))
        |-> (line_out[0] == line_out[1]));

endmodule

// File: tb/tb_blink_pwm_gen.sv
`timescale 1ns/100ps
module tb_blink_pwm_gen;

    localparam int NL = 8;
    localparam int CW = 8;
    localparam int AW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NL-1:0] line_out, line_oe;

    int tests = 0;
    int fails = 0;

    typedef struct {
        string req;
        int    line;
        int    hi;
        int    lo;
    } wave_item_t;

    wave_item_t sb_q[$];
    int sb_push = 0;
    int sb_done = 0;

    always #2.5 clk = ~clk;

    blink_pwm_gen #(.NUM_LINES(NL), .CNT_W(CW), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .line_out(line_out), .line_oe(line_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the following posedge
    task automatic bus_write(input int idx, input logic [DW-1:0] data);
        wr_en   = 1'b1;
        wr_addr = AW'(idx);
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Returns at the first negedge sample where the line has just gone high
    task automatic wait_rise(input int line);
        logic prev;
        prev = line_out[line];
        @(negedge clk);
        while (!(prev == 1'b0 && line_out[line] == 1'b1)) begin
            prev = line_out[line];
            @(negedge clk);
        end
    endtask

    // Driver: push an expected waveform and wait until the monitor has judged it
    task automatic expect_wave(input string req, input int line, input int hi, input int lo);
        wave_item_t it;
        it.req = req; it.line = line; it.hi = hi; it.lo = lo;
        sb_q.push_back(it);
        sb_push++;
        wait (sb_done == sb_push);
    endtask

    // Monitor: skip one period, then measure one high run and one low run
    initial begin
        forever begin
            wave_item_t it;
            int hi, lo;
            wait (sb_q.size() > 0);
            it = sb_q.pop_front();
            wait_rise(it.line);
            wait_rise(it.line);
            hi = 0;
            while (line_out[it.line]) begin hi++; @(negedge clk); end
            lo = 0;
            while (!line_out[it.line]) begin lo++; @(negedge clk); end
            check({it.req, " high run"}, hi, it.hi);
            check({it.req, " low run"}, lo, it.lo);
            sb_done++;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int bad;
        int hi;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 line_out", line_out, 0);
        check("R1 line_oe", line_oe, 0);

        // R2: static outputs
        bus_write(9, 32'hA5);
        bus_write(10, 32'h00);
        @(negedge clk);
        check("R2 static out", line_out, 8'hA5);
        check("R2 oe", line_oe, 8'hFF);

        // Program the sets: A 3/5, B 2/7; line1 on B; blink lines 0..2
        bus_write(0, 3);
        bus_write(1, 5);
        bus_write(2, 2);
        bus_write(3, 7);
        bus_write(8, 32'h02);
        bus_write(11, 32'h07);
        expect_wave("R3 set A", 0, 3, 5);
        expect_wave("R5 set B", 1, 2, 7);

        // R8: lines 0 and 2 share set A
        bad = 0;
        for (int k = 0; k < 40; k++) begin
            if (line_out[0] != line_out[2]) bad++;
            @(negedge clk);
        end
        check("R8 in-phase mismatches", bad, 0);
        check("R2 non-blink lines", line_out & 8'hF8, 8'hA0);

        // R6: line 3 is an input with blink enabled; its static bit is 0
        bus_write(10, 32'h08);
        bus_write(11, 32'h0F);
        bad = 0;
        for (int k = 0; k < 30; k++) begin
            if (line_out[3] !== 1'b0 || line_oe[3] !== 1'b0) bad++;
            @(negedge clk);
        end
        check("R6 input line kept static", bad, 0);

        // R7: rewrite the on-duration in the middle of a high phase
        bus_write(0, 6);
        bus_write(1, 4);
        expect_wave("R3 set A 6/4", 0, 6, 4);
        wait_rise(0);
        bus_write(0, 2);
        hi = 1;
        while (line_out[0]) begin hi++; @(negedge clk); end
        check("R7 running phase keeps old length", hi, 6);
        expect_wave("R7 new length", 0, 2, 4);

        // R4: zero on-duration means 2^CW cycles
        bus_write(0, 0);
        expect_wave("R4 zero duration", 0, 256, 4);

        // R9: an unmapped word index changes nothing
        bus_write(12, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R9 unmapped write out", line_out & 8'hF0, 8'hA0);
        check("R9 unmapped write oe", line_oe, 8'hF7);
        expect_wave("R9 set A intact", 0, 256, 4);

        // R2: clearing blink enable returns lines to their static bits
        bus_write(11, 32'h00);
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            if (line_out !== 8'hA5) bad++;
            @(negedge clk);
        end
        check("R2 blink disabled", bad, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule